// File: doc/BRIEF.md
# I2C Display Controller Write-Path Front End

This block is the bus-facing receiver of a display controller. It watches the two wires of an I2C bus, which are oversampled by a faster system clock. It responds to one 7-bit device address: the upper five bits are fixed at `01111` and the lower two bits come from two strap pins. Every byte of a write transfer addressed to it is acknowledged. Within a write transfer, control bytes decide where each payload byte goes. A payload byte is either handed to the command decoder as a one-cycle strobe, or written into display RAM at an auto-advancing pointer. A read transfer returns a fixed status byte for as long as the master keeps acknowledging.

A control byte has two meaningful bits. Bit 7 is the continuation flag: when it is 1, exactly one payload byte follows and then another control byte. Bit 6 is the destination flag: 0 sends the payload to the command port and 1 sends it to RAM. Bits 5:0 are ignored. When the continuation flag is 0, every later byte up to the next STOP or START is payload with the same destination. This lets one transfer carry several single command words and then a RAM burst. The RAM pointer survives between transfers. The command decoder reloads it through a load port, and it wraps to zero after a programmable last address.

The bit engine has the states `L_IDLE`, `L_ADDR`, `L_ADDR_ACK`, `L_WR_BYTE`, `L_WR_ACK`, `L_RD_BYTE` and `L_RD_ACK`. Its transitions are as follows:
- A STOP sends any state to `L_IDLE`, and a START sends any state to `L_ADDR`.
- After the eighth bit, `L_ADDR` goes to `L_ADDR_ACK` on an address hit, or to `L_IDLE` on a miss.
- `L_ADDR_ACK` goes to `L_WR_BYTE` or `L_RD_BYTE` according to the direction bit.
- `L_WR_BYTE` and `L_WR_ACK` alternate.
- `L_RD_BYTE` goes to `L_RD_ACK`, which returns to `L_RD_BYTE` on a master acknowledge or to `L_IDLE` on a not-acknowledge.

The control parser has the states `P_CTRL`, `P_SINGLE` and `P_STREAM`:
- In `P_CTRL`, a byte goes to `P_SINGLE` when bit 7 is 1, or to `P_STREAM` when bit 7 is 0.
- `P_SINGLE` goes back to `P_CTRL` after one payload byte.
- `P_STREAM` holds until the bus restarts.
- Any START or STOP sends the parser to `P_CTRL`.

Top module: `panel_i2c_ingress`

## Requirements
- R1: The address byte (7-bit address then direction bit, MSB first) is acknowledged only when its address equals `{5'b01111, sel_i[1:0]}`. On a mismatch, SDA is never pulled low and no command or RAM strobe occurs until the next START.
- R2: A START (SDA falling while SCL is high) or a STOP (SDA rising while SCL is high) makes the next byte an address byte. After a repeated START, the first byte following the address is again a control byte.
- R3: In a matched write transfer, `sda_oe` goes high only while SCL is low after the eighth bit of a byte, stays high through the ninth clock, and drops after the ninth falling edge. This holds for the address, control and payload bytes.
- R4: Only bit 7 (continuation) and bit 6 (destination, 1 = RAM) of a control byte matter. Bits 5:0 have no effect, and a control byte itself never produces a strobe.
- R5: With bit 7 set, exactly one payload byte follows, and the byte after it is decoded as a new control byte.
- R6: With bit 7 clear, every following byte until STOP or START is payload with the destination chosen, whatever its value.
- R7: A payload byte bound for the command port gives a one-cycle `cmd_valid` with `cmd_byte`. A payload byte bound for RAM gives a one-cycle `ram_we` with `ram_addr` equal to the current pointer and `ram_data`. The two strobes never coincide.
- R8: The pointer advances by one after each RAM write, and after a write at `ptr_last` it wraps to 0.
- R9: A one-cycle `ptr_load` sets the pointer to `ptr_value`, with priority over the advance. The pointer keeps its value across transfers.
- R10: After an address hit with direction bit 1, the block shifts out the `STATUS` parameter MSB first and repeats it after each master acknowledge. After a master not-acknowledge, it releases SDA and produces no strobes.
- R11: After reset, `sda_oe`, `cmd_valid` and `ram_we` are low and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe | output | 1 | 1 = pull SDA low (open-drain enable) |
| sel_i | input | 2 | Strap pins giving the two low address bits |
| ptr_load | input | 1 | Load pulse for the RAM pointer |
| ptr_value | input | AW | Value loaded into the RAM pointer |
| ptr_last | input | AW | Last RAM address before the pointer wraps to 0 |
| cmd_valid | output | 1 | One-cycle strobe for a command payload byte |
| cmd_byte | output | 8 | Command payload byte |
| ram_we | output | 1 | One-cycle display RAM write strobe |
| ram_addr | output | AW | Display RAM write address |
| ram_data | output | 8 | Display RAM write data |

## Verification
The embedded properties assume a legal bus:
- SDA moves only while SCL is low, except for START and STOP.
- The strap pins stay still during a transfer.
- The master never issues a START or STOP while the block is driving a read bit.

The bench keeps to these assumptions by building every waveform from master tasks. Each task changes SDA one half period (16 system clocks) before SCL rises, and each changes the straps and the pointer load only while the bus is idle. Because every half period spans many system clocks, the two-stage synchroniser lag cannot reorder a data edge against a clock edge.

// File: rtl/panel_i2c_pkg.sv
package panel_i2c_pkg;

    localparam logic [4:0] ADDR_PREFIX = 5'b01111;
    localparam int         CO_BIT      = 7;
    localparam int         DC_BIT      = 6;
    localparam int         BYTE_BITS   = 8;

    typedef enum logic [2:0] {
        L_IDLE,
        L_ADDR,
        L_ADDR_ACK,
        L_WR_BYTE,
        L_WR_ACK,
        L_RD_BYTE,
        L_RD_ACK
    } link_state_t;

    typedef enum logic [1:0] {
        P_CTRL,
        P_SINGLE,
        P_STREAM
    } parse_state_t;

endpackage

// File: rtl/pi_line_sync.sv
module pi_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] scl_pipe;
    logic [DEPTH-1:0] sda_pipe;
    logic             scl_prev;
    logic             sda_prev;

    // Idle bus is high: preset the pipes to ones so reset never looks like an edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[DEPTH-2:0], scl_i};
            sda_pipe <= {sda_pipe[DEPTH-2:0], sda_i};
        end
    end

    always_comb begin
        scl_lvl   = scl_pipe[STAGES-1];
        sda_lvl   = sda_pipe[STAGES-1];
        scl_prev  = scl_pipe[STAGES];
        sda_prev  = sda_pipe[STAGES];
        scl_rise  = scl_lvl & ~scl_prev;
        scl_fall  = ~scl_lvl & scl_prev;
        start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
        stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
    end

    // R2: a bus condition can only be seen while the clock line stays high
    p_cond_scl_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det || stop_det) |-> (scl_lvl && $past(scl_lvl)));

endmodule

// File: rtl/pi_link.sv
module pi_link
    import panel_i2c_pkg::*;
#(
    parameter logic [7:0] STATUS = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_lvl,
    input  logic       sda_lvl,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic [1:0] sel_i,
    output logic       sda_oe,
    output logic       byte_stb,
    output logic [7:0] rx_byte,
    output logic       bus_restart
);

    localparam int          CNT_W    = $clog2(BYTE_BITS + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS);

    link_state_t       state;
    link_state_t       state_n;
    logic [CNT_W-1:0]  bit_cnt;
    logic [7:0]        shift_in;
    logic [7:0]        shift_out;
    logic              dir_read;
    logic              master_ack;
    logic              stb_q;
    logic [7:0]        rx_q;
    logic              addr_hit;
    logic              byte_end;

    always_comb begin
        addr_hit = (shift_in[7:1] == {ADDR_PREFIX, sel_i});
        byte_end = scl_fall && (bit_cnt == LAST_BIT);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= L_IDLE;
        else        state <= state_n;
    end

    // next-state decision
    always_comb begin
        state_n = state;
        if (stop_det) begin
            state_n = L_IDLE;
        end else if (start_det) begin
            state_n = L_ADDR;
        end else begin
            unique case (state)
                L_IDLE:     state_n = L_IDLE;
                L_ADDR:     if (byte_end) state_n = addr_hit ? L_ADDR_ACK : L_IDLE;
                L_ADDR_ACK: if (scl_fall) state_n = dir_read ? L_RD_BYTE : L_WR_BYTE;
                L_WR_BYTE:  if (byte_end) state_n = L_WR_ACK;
                L_WR_ACK:   if (scl_fall) state_n = L_WR_BYTE;
                L_RD_BYTE:  if (byte_end) state_n = L_RD_ACK;
                L_RD_ACK:   if (scl_fall) state_n = master_ack ? L_RD_BYTE : L_IDLE;
                default:    state_n = L_IDLE;
            endcase
        end
    end

    // bit counter, shifters and byte strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt    <= '0;
            shift_in   <= '0;
            shift_out  <= STATUS;
            dir_read   <= 1'b0;
            master_ack <= 1'b0;
            stb_q      <= 1'b0;
            rx_q       <= '0;
        end else begin
            stb_q <= 1'b0;
            if (start_det || stop_det) begin
                bit_cnt <= '0;
            end else begin
                unique case (state)
                    L_ADDR, L_WR_BYTE: begin
                        if (scl_rise && bit_cnt != LAST_BIT) begin
                            shift_in <= {shift_in[6:0], sda_lvl};
                            bit_cnt  <= bit_cnt + 1'b1;
                        end else if (byte_end) begin
                            bit_cnt <= '0;
                            if (state == L_ADDR) begin
                                dir_read <= shift_in[0];
                            end else begin
                                stb_q <= 1'b1;
                                rx_q  <= shift_in;
                            end
                        end
                    end
                    L_ADDR_ACK: begin
                        if (scl_fall) begin
                            bit_cnt   <= '0;
                            shift_out <= STATUS;
                        end
                    end
                    L_RD_BYTE: begin
                        if (scl_rise && bit_cnt != LAST_BIT) begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (byte_end) begin
                            bit_cnt <= '0;
                        end else if (scl_fall) begin
                            shift_out <= {shift_out[6:0], 1'b0};
                        end
                    end
                    L_RD_ACK: begin
                        if (scl_rise) begin
                            master_ack <= ~sda_lvl;
                        end else if (scl_fall) begin
                            shift_out <= STATUS;
                            bit_cnt   <= '0;
                        end
                    end
                    default: begin
                        bit_cnt <= bit_cnt;
                    end
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        sda_oe      = (state == L_ADDR_ACK) || (state == L_WR_ACK) ||
                      ((state == L_RD_BYTE) && !shift_out[7]);
        byte_stb    = stb_q;
        rx_byte     = rx_q;
        bus_restart = start_det | stop_det;
    end

    // R3: the line is only ever pulled while the clock line is low
    p_oe_rise_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_lvl);

    // R1: an acknowledge of the address byte belongs to a matching address
    p_ack_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == L_ADDR_ACK) |-> (shift_in[7:1] == {ADDR_PREFIX, sel_i}));

    // R3: every delivered byte is followed by its acknowledge slot
    p_stb_in_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        byte_stb |-> (state == L_WR_ACK));

    // R10: read transfers never deliver a payload strobe
    p_read_no_stb_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == L_RD_BYTE || state == L_RD_ACK) |-> !byte_stb);

endmodule

// File: rtl/pi_ctrl_parse.sv
module pi_ctrl_parse
    import panel_i2c_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_stb,
    input  logic [7:0] rx_byte,
    input  logic       bus_restart,
    output logic       ram_req,
    output logic       cmd_valid,
    output logic [7:0] cmd_byte
);

    parse_state_t state;
    parse_state_t state_n;
    logic         to_ram;
    logic         routed;
    logic         cmd_q;
    logic [7:0]   cmd_byte_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= P_CTRL;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        if (bus_restart) begin
            state_n = P_CTRL;
        end else if (byte_stb) begin
            unique case (state)
                P_CTRL:   state_n = rx_byte[CO_BIT] ? P_SINGLE : P_STREAM;
                P_SINGLE: state_n = P_CTRL;
                P_STREAM: state_n = P_STREAM;
                default:  state_n = P_CTRL;
            endcase
        end
    end

    // destination flag captured from each control byte; command output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            to_ram     <= 1'b0;
            cmd_q      <= 1'b0;
            cmd_byte_q <= '0;
        end else begin
            cmd_q <= 1'b0;
            if (byte_stb && state == P_CTRL) begin
                to_ram <= rx_byte[DC_BIT];
            end
            if (routed && !to_ram) begin
                cmd_q      <= 1'b1;
                cmd_byte_q <= rx_byte;
            end
        end
    end

    // outputs
    always_comb begin
        routed    = byte_stb && (state != P_CTRL);
        ram_req   = routed && to_ram;
        cmd_valid = cmd_q;
        cmd_byte  = cmd_byte_q;
    end

    // R4: a control byte never turns into a command strobe
    p_ctrl_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stb && state == P_CTRL) |=> !cmd_valid);

    // R6: a stream persists until the bus restarts
    p_stream_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == P_STREAM && !bus_restart) |=> (state == P_STREAM));

    // R5: a single-word payload returns the parser to control decoding
    p_single_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == P_SINGLE && byte_stb) |=> (state == P_CTRL));

endmodule

// File: rtl/pi_data_ptr.sv
module pi_data_ptr #(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ram_req,
    input  logic [7:0]    wr_byte,
    input  logic          ptr_load,
    input  logic [AW-1:0] ptr_value,
    input  logic [AW-1:0] ptr_last,
    output logic          ram_we,
    output logic [AW-1:0] ram_addr,
    output logic [7:0]    ram_data
);

    localparam logic [AW-1:0] PTR_ONE = AW'(1);

    logic [AW-1:0] ptr;
    logic [AW-1:0] ptr_next;
    logic          we_q;
    logic [AW-1:0] addr_q;
    logic [7:0]    data_q;

    always_comb begin
        ptr_next = (ptr == ptr_last) ? '0 : ptr + PTR_ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr    <= '0;
            we_q   <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            we_q <= ram_req;
            if (ram_req) begin
                addr_q <= ptr;
                data_q <= wr_byte;
            end
            if (ptr_load)     ptr <= ptr_value;
            else if (ram_req) ptr <= ptr_next;
        end
    end

    always_comb begin
        ram_we   = we_q;
        ram_addr = addr_q;
        ram_data = data_q;
    end

    // R8: ordinary advance
    p_ptr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_req && !ptr_load && ptr != ptr_last) |=> (ptr == $past(ptr) + PTR_ONE));

    // R8: wrap after the last address
    p_ptr_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_req && !ptr_load && ptr == ptr_last) |=> (ptr == '0));

    // R9: load wins over advance
    p_ptr_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_load |=> (ptr == $past(ptr_value)));

    // R9: without traffic the pointer holds
    p_ptr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ptr_load && !ram_req) |=> $stable(ptr));

    // R7: the write address is the pointer value before the advance
    p_we_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_req && !ptr_load) |=> (ram_addr == $past(ptr) && ram_we));

endmodule

// File: rtl/panel_i2c_ingress.sv
module panel_i2c_ingress #(
    parameter int         AW          = 7,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] STATUS      = 8'h00
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe,
    input  logic [1:0]    sel_i,
    input  logic          ptr_load,
    input  logic [AW-1:0] ptr_value,
    input  logic [AW-1:0] ptr_last,
    output logic          cmd_valid,
    output logic [7:0]    cmd_byte,
    output logic          ram_we,
    output logic [AW-1:0] ram_addr,
    output logic [7:0]    ram_data
);

    logic       scl_lvl;
    logic       sda_lvl;
    logic       scl_rise;
    logic       scl_fall;
    logic       start_det;
    logic       stop_det;
    logic       byte_stb;
    logic [7:0] rx_byte;
    logic       bus_restart;
    logic       ram_req;

    pi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    pi_link #(.STATUS(STATUS)) u_link (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_lvl     (scl_lvl),
        .sda_lvl     (sda_lvl),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .start_det   (start_det),
        .stop_det    (stop_det),
        .sel_i       (sel_i),
        .sda_oe      (sda_oe),
        .byte_stb    (byte_stb),
        .rx_byte     (rx_byte),
        .bus_restart (bus_restart)
    );

    pi_ctrl_parse u_parse (
        .clk         (clk),
        .rst_n       (rst_n),
        .byte_stb    (byte_stb),
        .rx_byte     (rx_byte),
        .bus_restart (bus_restart),
        .ram_req     (ram_req),
        .cmd_valid   (cmd_valid),
        .cmd_byte    (cmd_byte)
    );

    pi_data_ptr #(.AW(AW)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ram_req   (ram_req),
        .wr_byte   (rx_byte),
        .ptr_load  (ptr_load),
        .ptr_value (ptr_value),
        .ptr_last  (ptr_last),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_data  (ram_data)
    );

    // R7: command and RAM strobes are mutually exclusive
    p_one_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_valid, ram_we}));

endmodule

// File: tb/panel_i2c_ingress_bench.sv
module panel_i2c_ingress_bench;

    localparam int         AW   = 7;
    localparam int         H    = 16;
    localparam logic [7:0] STAT = 8'hA6;
    localparam logic [AW-1:0] LAST = 7'd9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scl_m = 1'b1;
    logic          sda_m = 1'b1;
    logic          sda_bus;
    logic          sda_oe;
    logic [1:0]    sel = 2'b10;
    logic          ptr_load = 1'b0;
    logic [AW-1:0] ptr_value = '0;
    logic          cmd_valid;
    logic [7:0]    cmd_byte;
    logic          ram_we;
    logic [AW-1:0] ram_addr;
    logic [7:0]    ram_data;

    int errors = 0;
    int checks = 0;
    int cmd_n  = 0;
    int ram_n  = 0;
    logic [7:0]    cmd_log  [64];
    logic [7:0]    ramd_log [64];
    logic [AW-1:0] rama_log [64];
    logic [AW-1:0] mptr = '0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    panel_i2c_ingress #(.AW(AW), .SYNC_STAGES(2), .STATUS(STAT)) u_panel_i2c_ingress (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_bus),
        .sda_oe    (sda_oe),
        .sel_i     (sel),
        .ptr_load  (ptr_load),
        .ptr_value (ptr_value),
        .ptr_last  (LAST),
        .cmd_valid (cmd_valid),
        .cmd_byte  (cmd_byte),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_data  (ram_data)
    );

    always @(negedge clk) begin
        if (cmd_valid && cmd_n < 64) begin
            cmd_log[cmd_n] = cmd_byte;
            cmd_n = cmd_n + 1;
        end
        if (ram_we && ram_n < 64) begin
            ramd_log[ram_n] = ram_data;
            rama_log[ram_n] = ram_addr;
            ram_n = ram_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hw();
        repeat (H) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hw();
        scl_m = 1'b1; hw();
        sda_m = 1'b0; hw();
        scl_m = 1'b0; hw();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hw();
        scl_m = 1'b1; hw();
        sda_m = 1'b1; hw();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hw();
            scl_m = 1'b1; hw();
            scl_m = 1'b0;
        end
        sda_m = 1'b1; hw();
        scl_m = 1'b1; hw();
        ack = ~sda_bus;
        scl_m = 1'b0;
    endtask

    task automatic read_byte(input bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hw();
            scl_m = 1'b1; hw();
            b[i] = sda_bus;
            scl_m = 1'b0;
        end
        sda_m = give_ack ? 1'b0 : 1'b1; hw();
        scl_m = 1'b1; hw();
        scl_m = 1'b0; hw();
        sda_m = 1'b1;
    endtask

    task automatic load_ptr(input logic [AW-1:0] v);
        @(negedge clk);
        ptr_value = v;
        ptr_load  = 1'b1;
        @(negedge clk);
        ptr_load  = 1'b0;
        mptr      = v;
    endtask

    task automatic expect_ram(input int idx, input logic [7:0] d, input string req);
        chk(ramd_log[idx] == d, req, ramd_log[idx], d);
        chk(rama_log[idx] == mptr, {req, " addr"}, rama_log[idx], mptr);
        mptr = (mptr == LAST) ? '0 : mptr + 1'b1;
    endtask

    // {sel, addr byte, control byte, payload, expected ack, kind: 0 none, 1 cmd, 2 ram}
    localparam logic [28:0] VEC [0:6] = '{
        {2'b10, 8'h7C, 8'h80, 8'hA5, 1'b1, 2'd1},   // R1 R7 command word
        {2'b10, 8'h7C, 8'hC0, 8'h3C, 1'b1, 2'd2},   // R7 RAM word
        {2'b01, 8'h7A, 8'hBF, 8'h5A, 1'b1, 2'd1},   // R4 low bits ignored
        {2'b01, 8'h7C, 8'hC0, 8'h77, 1'b0, 2'd0},   // R1 wrong strap
        {2'b00, 8'h78, 8'h7F, 8'h11, 1'b1, 2'd2},   // R6 R4 stream to RAM
        {2'b11, 8'h7E, 8'h00, 8'h42, 1'b1, 2'd1},   // R6 stream to command
        {2'b00, 8'hF0, 8'h80, 8'h99, 1'b0, 2'd0}    // R1 wrong prefix
    };

    initial begin
        bit a0, a1, a2;
        logic [7:0] rb;
        int c0, r0;

        repeat (5) @(negedge clk);
        // R11 reset state
        chk(sda_oe == 1'b0, "R11 sda_oe", sda_oe, 0);
        chk(cmd_valid == 1'b0 && ram_we == 1'b0, "R11 strobes", {cmd_valid, ram_we}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        load_ptr(7'd3);

        for (int i = 0; i < 7; i++) begin
            logic [28:0] v;
            v   = VEC[i];
            sel = v[28:27];
            c0 = cmd_n; r0 = ram_n;
            bus_start();
            send_byte(v[26:19], a0);
            send_byte(v[18:11], a1);
            send_byte(v[10:3], a2);
            bus_stop();
            repeat (8) @(negedge clk);
            chk(a0 == v[2], "R1 address ack", a0, v[2]);
            chk(a1 == v[2] && a2 == v[2], "R3 byte acks", {a1, a2}, {v[2], v[2]});
            unique case (v[1:0])
                2'd0: chk(cmd_n == c0 && ram_n == r0, "R1 ignored", cmd_n + ram_n, c0 + r0);
                2'd1: begin
                    chk(cmd_n == c0 + 1 && ram_n == r0, "R7 cmd count", cmd_n, c0 + 1);
                    chk(cmd_log[c0] == v[10:3], "R7 cmd byte", cmd_log[c0], v[10:3]);
                end
                default: begin
                    chk(ram_n == r0 + 1 && cmd_n == c0, "R7 ram count", ram_n, r0 + 1);
                    expect_ram(r0, v[10:3], "R7 ram data");
                end
            endcase
        end

        // R5 R6 R8: mixed words, then a wrapping burst
        sel = 2'b10;
        load_ptr(7'd8);
        c0 = cmd_n; r0 = ram_n;
        bus_start();
        send_byte(8'h7C, a0);
        send_byte(8'h81, a1); send_byte(8'h11, a2);
        send_byte(8'hC0, a1); send_byte(8'h22, a2);
        send_byte(8'h40, a1); send_byte(8'h33, a2);
        send_byte(8'h44, a1); send_byte(8'h55, a2);
        bus_stop();
        repeat (8) @(negedge clk);
        chk(cmd_n == c0 + 1, "R5 one command", cmd_n, c0 + 1);
        chk(cmd_log[c0] == 8'h11, "R5 command byte", cmd_log[c0], 8'h11);
        chk(ram_n == r0 + 4, "R6 burst length", ram_n, r0 + 4);
        expect_ram(r0,     8'h22, "R5 ram after control");
        expect_ram(r0 + 1, 8'h33, "R8 burst at last");
        expect_ram(r0 + 2, 8'h44, "R8 wrap to zero");
        expect_ram(r0 + 3, 8'h55, "R8 after wrap");

        // R6: control-looking bytes inside a stream are payload; R9 pointer kept
        c0 = cmd_n; r0 = ram_n;
        bus_start();
        send_byte(8'h7C, a0);
        send_byte(8'h40, a1);
        send_byte(8'h80, a2);
        send_byte(8'hC0, a2);
        bus_stop();
        repeat (8) @(negedge clk);
        chk(ram_n == r0 + 2 && cmd_n == c0, "R6 stream bytes", ram_n, r0 + 2);
        expect_ram(r0,     8'h80, "R9 pointer kept");
        expect_ram(r0 + 1, 8'hC0, "R6 stream payload");

        // R2: repeated START returns to address, then control
        c0 = cmd_n; r0 = ram_n;
        bus_start();
        send_byte(8'h7C, a0);
        send_byte(8'h00, a1);
        send_byte(8'h10, a2);
        bus_start();
        send_byte(8'h7C, a0);
        send_byte(8'hC0, a1);
        send_byte(8'h99, a2);
        bus_stop();
        repeat (8) @(negedge clk);
        chk(a0 == 1'b1, "R2 restart address ack", a0, 1);
        chk(cmd_n == c0 + 1 && cmd_log[c0] == 8'h10, "R2 first part", cmd_n, c0 + 1);
        chk(ram_n == r0 + 1, "R2 control after restart", ram_n, r0 + 1);
        expect_ram(r0, 8'h99, "R2 ram after restart");

        // R10: status read, ack then not-ack
        c0 = cmd_n; r0 = ram_n;
        bus_start();
        send_byte(8'h7D, a0);
        read_byte(1'b1, rb);
        chk(rb == STAT, "R10 status first", rb, STAT);
        read_byte(1'b0, rb);
        chk(rb == STAT, "R10 status repeat", rb, STAT);
        chk(sda_oe == 1'b0, "R10 released", sda_oe, 0);
        bus_stop();
        repeat (8) @(negedge clk);
        chk(a0 == 1'b1, "R10 read address ack", a0, 1);
        chk(cmd_n == c0 && ram_n == r0, "R10 no strobes", cmd_n + ram_n, c0 + r0);

        // R11: reset clears the pointer
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mptr = '0;
        repeat (3) @(negedge clk);
        r0 = ram_n;
        bus_start();
        send_byte(8'h7C, a0);
        send_byte(8'hC0, a1);
        send_byte(8'h5E, a2);
        bus_stop();
        repeat (8) @(negedge clk);
        chk(ram_n == r0 + 1, "R11 write after reset", ram_n, r0 + 1);
        expect_ram(r0, 8'h5E, "R11 pointer zero");

        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (150000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule